// File: doc/BRIEF.md
# Accumulator Shifter with Condition Flags

This block shifts operands for a 36-bit accumulator datapath and produces the result with five condition flags: sign (N), overflow (V), carry (C), extension-in-use (E) and zero (Z). There are four operations. The first is a one-place arithmetic left shift. The second is a left shift by a variable amount. The last two shift right, arithmetically or logically, and add the shifted value into an accumulator. Operands come in three classes: a 36-bit accumulator, a 32-bit long register and a 16-bit word register. Only the low bits that belong to the class are used.

Two global controls change how the flags are computed. The first is a condition-code width select, `cmMode`: 0 selects 36-bit flag rules and 1 selects 32-bit flag rules. The second is `satEn`, which enables an output limiter. The limiter clamps accumulator-destined results that spill into the extension bits. Every strobe on `inValid` yields a registered result and flags one clock later, marked by a single-cycle `done`.

Top module: `acc_shift_unit`

## Requirements
- R1: The inputs are sampled at a rising edge where `inValid`=1. The result and flags are written at that edge, and `done` is 1 for exactly the following cycle. With `inValid`=0, the result and flags hold and `done` is 0. After reset, every output is 0.
- R2: `opClass` selects the class width: 0 is the 36-bit accumulator, 1 is the 32-bit long register, 2 is the 16-bit word register, and 3 acts as an accumulator. Operand bits above the class width are ignored. For the two left-shift operations (`opcode` 0 and 1), result bits above the class width are 0.
- R3: For the one-place left shift (`opcode` 0), C is the source MSB before the shift. This is bit 35 for an accumulator with `cmMode`=0, bit 31 for an accumulator with `cmMode`=1, bit 31 for the long class and bit 15 for the word class.
- R4: For `opcode` 0, V is set whenever the limiter saturates. Otherwise, for an accumulator with `cmMode`=1, V equals E. In every other case, V is 1 exactly when the class MSB of the result differs from the class MSB of the source.
- R5: E is 1 when bits 35..31 of the accumulator-destined result before limiting are not all equal. E is always 0 for left shifts of the long and word classes.
- R6: With `satEn`=1, the limiter acts on accumulator-destined results of `opcode` 0, 2 and 3 whenever E=1. It replaces the result with 0x07FFFFFFF for a positive true value and 0xF80000000 for a negative one. The true sign is source bit 35 for the left shift and the sign of the exact sum for the accumulate operations.
- R7: For the variable left shift (`opcode` 1), the operand is shifted left by `shAmt` within the class width. C is the last bit shifted out, or 0 when `shAmt` is 0 or larger than the class width. V is 0 and the limiter never acts.
- R8: For `opcode` 2 (arithmetic) and `opcode` 3 (logical), the class-width operand is sign-extended (op 2) or zero-extended (op 3) to 36 bits. It is then shifted right by `shAmt` and added to `accIn` modulo 2^36. C is the carry out of bit 35. V is the signed overflow of the addition, or the limiter saturating.
- R9: For `opcode` 2 and 3, N is result bit 35 when `satEn`=0 and `cmMode`=0. Otherwise, N is bit 31 of the sum before the limiter.
- R10: For `opcode` 0, N is the class MSB of the result. For an accumulator this is bit 35 with `cmMode`=0 and bit 31 with `cmMode`=1.
- R11: For `opcode` 1, N is forced to 0 when `cmMode`=1. With `cmMode`=0, N is the class MSB of the result.
- R12: Z is 1 when the checked result bits are all zero. The checked bits are 31..0 for accumulator-destined results with `cmMode`=1, and all 36 bits in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Start strobe for one operation |
| opcode | input | 2 | Operation: 0 shift left one, 1 shift left by amount, 2 arithmetic right and add, 3 logical right and add |
| opClass | input | 2 | Operand class: 0 accumulator, 1 long, 2 word, 3 accumulator |
| operand | input | 36 | Source operand, low bits per class |
| accIn | input | 36 | Accumulator addend for operations 2 and 3 |
| shAmt | input | 5 | Shift amount for operations 1, 2 and 3 |
| cmMode | input | 1 | Flag width select: 0 for 36-bit rules, 1 for 32-bit rules |
| satEn | input | 1 | Output limiter enable |
| result | output | 36 | Registered result |
| flagN | output | 1 | Sign flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag |
| flagE | output | 1 | Extension-in-use flag |
| flagZ | output | 1 | Zero flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a saturating accumulate whose exact sum has a sign that differs from bit 35 of the wrapped 36-bit sum. In that case the limiter must use the true sign, and N must come from the pre-limit bit 31 rather than from the clamped value. The stimulus gets there by adding two large negative accumulator values so that the addition overflows into a positive-looking word. That vector is driven once with the limiter on and once with it off. Similar paired vectors cover one-place left shifts under both flag-width modes, where V changes its source from the MSB-change rule to E.

// File: rtl/acc_shift_pkg.sv
`timescale 1ns/1ps
package acc_shift_pkg;
  localparam int ACC_WIDTH  = 36;
  localparam int LONG_WIDTH = 32;
  localparam int WORD_WIDTH = 16;
  localparam int AMT_WIDTH  = 5;

  typedef enum logic [1:0] {
    SH_LEFT1     = 2'd0,
    SH_LEFTN     = 2'd1,
    SH_RARITHACC = 2'd2,
    SH_RLOGICACC = 2'd3
  } shOp_e;

  typedef enum logic [1:0] {
    CL_ACC  = 2'd0,
    CL_LONG = 2'd1,
    CL_WORD = 2'd2,
    CL_ALT  = 2'd3
  } opClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture result and flags
    logic accDest;   // destination is an accumulator
    logic limitEn;   // limiter may clamp
    logic nZero;     // sign flag forced low
    logic nPreLim;   // sign flag from pre-limit bit 31
    logic zNarrow;   // zero test on low 32 bits only
    logic cNarrow;   // carry from bit 31 of an accumulator
    logic vFromExt;  // overflow copies the extension flag
  } ctrlStrobe_t;
endpackage

// File: rtl/acc_shift_ctrl.sv
`timescale 1ns/1ps
module acc_shift_ctrl
  import acc_shift_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  shOp_e       op,
  input  opClass_e    cls,
  input  logic        cmMode,
  input  logic        satEn,
  output ctrlStrobe_t strobe,
  output logic        done
);
  logic isAccum;
  logic accClass;
  logic isLeft1;

  always_comb begin
    isAccum  = (op == SH_RARITHACC) || (op == SH_RLOGICACC);
    accClass = (cls == CL_ACC) || (cls == CL_ALT);
    isLeft1  = (op == SH_LEFT1);

    strobe.load     = inValid;
    strobe.accDest  = isAccum || accClass;
    strobe.limitEn  = satEn && (isAccum || (isLeft1 && accClass));
    strobe.nZero    = cmMode && (op == SH_LEFTN);
    strobe.nPreLim  = isAccum && (cmMode || satEn);
    strobe.zNarrow  = cmMode && (isAccum || accClass);
    strobe.cNarrow  = cmMode && isLeft1 && accClass;
    strobe.vFromExt = cmMode && isLeft1 && accClass;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= inValid;
  end
endmodule

// File: rtl/acc_shift_limiter.sv
`timescale 1ns/1ps
module acc_shift_limiter #(
  parameter int ACC_W  = 36,
  parameter int LONG_W = 32
) (
  input  logic [ACC_W-1:0] valueIn,
  input  logic             signIn,
  input  logic             enable,
  output logic [ACC_W-1:0] valueOut,
  output logic             saturated,
  output logic             extInUse
);
  localparam int GUARD_W = ACC_W - LONG_W + 1;
  localparam logic [ACC_W-1:0] SAT_POS = {{GUARD_W{1'b0}}, {(LONG_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_NEG = ~SAT_POS;

  logic [GUARD_W-1:0] guardBits;

  always_comb begin
    guardBits = valueIn[ACC_W-1:LONG_W-1];
    extInUse  = !((guardBits == '0) || (guardBits == '1));
    saturated = enable && extInUse;
    if (saturated) valueOut = signIn ? SAT_NEG : SAT_POS;
    else           valueOut = valueIn;
  end
endmodule

// File: rtl/acc_shift_datapath.sv
`timescale 1ns/1ps
module acc_shift_datapath
  import acc_shift_pkg::*;
#(
  parameter int ACC_W  = ACC_WIDTH,
  parameter int LONG_W = LONG_WIDTH,
  parameter int WORD_W = WORD_WIDTH,
  parameter int AMT_W  = AMT_WIDTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  shOp_e             op,
  input  opClass_e          cls,
  input  logic [ACC_W-1:0]  operand,
  input  logic [ACC_W-1:0]  accIn,
  input  logic [AMT_W-1:0]  shAmt,
  output logic [ACC_W-1:0]  result,
  output logic              flagN,
  output logic              flagV,
  output logic              flagC,
  output logic              flagE,
  output logic              flagZ
);
  localparam int WIDE_W = 2 * ACC_W;
  localparam logic [ACC_W-1:0] ALL_ONES  = '1;
  localparam logic [ACC_W-1:0] LONG_MASK = ~(ALL_ONES << LONG_W);

  int               srcW;
  int               nIdx;
  logic [ACC_W-1:0] widthMask;
  logic [ACC_W-1:0] src;
  logic             srcSign;
  logic             srcNext;
  logic [ACC_W-1:0] left1Res;
  logic [WIDE_W-1:0] wideShift;
  logic [ACC_W-1:0] leftNRes;
  logic [ACC_W-1:0] extended;
  logic [ACC_W-1:0] rightShifted;
  logic [ACC_W:0]   sum;
  logic             addOvf;
  logic [ACC_W-1:0] preLim;
  logic             limSign;
  logic [ACC_W-1:0] limOut;
  logic             satHit;
  logic             extBits;
  logic             extFlag;
  logic [ACC_W-1:0] zMask;
  logic             nNext, vNext, cNext, zNext;

  // Operand conditioning and the three shifters
  always_comb begin
    case (cls)
      CL_LONG: srcW = LONG_W;
      CL_WORD: srcW = WORD_W;
      default: srcW = ACC_W;
    endcase
    widthMask = ~(ALL_ONES << srcW);
    src       = operand & widthMask;
    srcSign   = src[srcW-1];
    srcNext   = src[srcW-2];

    left1Res  = (src << 1) & widthMask;

    wideShift = {{ACC_W{1'b0}}, src} << shAmt;
    leftNRes  = wideShift[ACC_W-1:0] & widthMask;

    if (op == SH_RARITHACC && srcSign) extended = src | ~widthMask;
    else                               extended = src;
    if (op == SH_RARITHACC) rightShifted = ACC_W'($signed(extended) >>> shAmt);
    else                    rightShifted = extended >> shAmt;

    sum    = {1'b0, accIn} + {1'b0, rightShifted};
    addOvf = (accIn[ACC_W-1] == rightShifted[ACC_W-1]) &&
             (sum[ACC_W-1] != accIn[ACC_W-1]);

    case (op)
      SH_LEFT1: preLim = left1Res;
      SH_LEFTN: preLim = leftNRes;
      default:  preLim = sum[ACC_W-1:0];
    endcase
    limSign = (op == SH_LEFT1) ? src[ACC_W-1] : (sum[ACC_W-1] ^ addOvf);
  end

  acc_shift_limiter #(.ACC_W(ACC_W), .LONG_W(LONG_W)) u_limiter (
    .valueIn  (preLim),
    .signIn   (limSign),
    .enable   (strobe.limitEn),
    .valueOut (limOut),
    .saturated(satHit),
    .extInUse (extBits)
  );

  // Flag formation
  always_comb begin
    extFlag = strobe.accDest && extBits;

    if (strobe.zNarrow)      nIdx = LONG_W - 1;
    else if (strobe.accDest) nIdx = ACC_W - 1;
    else                     nIdx = srcW - 1;

    if (strobe.nZero)        nNext = 1'b0;
    else if (strobe.nPreLim) nNext = preLim[LONG_W-1];
    else                     nNext = limOut[nIdx];

    case (op)
      SH_LEFT1: begin
        if (satHit)               vNext = 1'b1;
        else if (strobe.vFromExt) vNext = extFlag;
        else                      vNext = srcSign ^ srcNext;
        cNext = strobe.cNarrow ? src[LONG_W-1] : srcSign;
      end
      SH_LEFTN: begin
        vNext = 1'b0;
        cNext = wideShift[srcW];
      end
      default: begin
        vNext = addOvf || satHit;
        cNext = sum[ACC_W];
      end
    endcase

    zMask = strobe.zNarrow ? LONG_MASK : ALL_ONES;
    zNext = ((limOut & zMask) == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      flagN  <= 1'b0;
      flagV  <= 1'b0;
      flagC  <= 1'b0;
      flagE  <= 1'b0;
      flagZ  <= 1'b0;
    end else if (strobe.load) begin
      result <= limOut;
      flagN  <= nNext;
      flagV  <= vNext;
      flagC  <= cNext;
      flagE  <= extFlag;
      flagZ  <= zNext;
    end
  end
endmodule

// File: rtl/acc_shift_unit.sv
`timescale 1ns/1ps
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter int ACC_W  = ACC_WIDTH,
  parameter int LONG_W = LONG_WIDTH,
  parameter int WORD_W = WORD_WIDTH,
  parameter int AMT_W  = AMT_WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       opcode,
  input  logic [1:0]       opClass,
  input  logic [ACC_W-1:0] operand,
  input  logic [ACC_W-1:0] accIn,
  input  logic [AMT_W-1:0] shAmt,
  input  logic             cmMode,
  input  logic             satEn,
  output logic [ACC_W-1:0] result,
  output logic             flagN,
  output logic             flagV,
  output logic             flagC,
  output logic             flagE,
  output logic             flagZ,
  output logic             done
);
  shOp_e       opSel;
  opClass_e    clsSel;
  ctrlStrobe_t strobe;

  assign opSel  = shOp_e'(opcode);
  assign clsSel = opClass_e'(opClass);

  acc_shift_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .op     (opSel),
    .cls    (clsSel),
    .cmMode (cmMode),
    .satEn  (satEn),
    .strobe (strobe),
    .done   (done)
  );

  acc_shift_datapath #(
    .ACC_W(ACC_W), .LONG_W(LONG_W), .WORD_W(WORD_W), .AMT_W(AMT_W)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .op     (opSel),
    .cls    (clsSel),
    .operand(operand),
    .accIn  (accIn),
    .shAmt  (shAmt),
    .result (result),
    .flagN  (flagN),
    .flagV  (flagV),
    .flagC  (flagC),
    .flagE  (flagE),
    .flagZ  (flagZ)
  );
endmodule

// File: rtl/acc_shift_unit_checker.sv
`timescale 1ns/1ps
module acc_shift_unit_checker #(
  parameter int ACC_W  = 36,
  parameter int LONG_W = 32,
  parameter int WORD_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [1:0]       opcode,
  input logic [1:0]       opClass,
  input logic             cmMode,
  input logic             satEn,
  input logic [ACC_W-1:0] result,
  input logic             flagN,
  input logic             flagV,
  input logic             flagE,
  input logic             flagZ,
  input logic             done
);
  localparam logic [ACC_W-1:0] POS_CLAMP = {{(ACC_W-LONG_W+1){1'b0}}, {(LONG_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_CLAMP = ~POS_CLAMP;

  a_r1_done_after_valid: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> done);
  a_r1_no_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !done);
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));
  a_r2_word_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opClass == 2'd2 && !opcode[1]) |=> (result[ACC_W-1:WORD_W] == '0));
  a_r6_left_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && satEn && opcode == 2'd0 && (opClass == 2'd0 || opClass == 2'd3))
      |=> (!flagE || ((result == POS_CLAMP || result == NEG_CLAMP) && flagV)));
  a_r11_n_forced_low: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cmMode && opcode == 2'd1) |=> !flagN);
  a_r12_zero_wide: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !cmMode) |=> (flagZ == (result == '0)));
endmodule

bind acc_shift_unit acc_shift_unit_checker #(
  .ACC_W(ACC_W), .LONG_W(LONG_W), .WORD_W(WORD_W)
) u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .inValid(inValid),
  .opcode (opcode),
  .opClass(opClass),
  .cmMode (cmMode),
  .satEn  (satEn),
  .result (result),
  .flagN  (flagN),
  .flagV  (flagV),
  .flagE  (flagE),
  .flagZ  (flagZ),
  .done   (done)
);

// File: tb/acc_shift_unit_bench.sv
`timescale 1ns/1ps
module acc_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opcode = '0;
  logic [1:0]  opClass = '0;
  logic [35:0] operand = '0;
  logic [35:0] accIn = '0;
  logic [4:0]  shAmt = '0;
  logic        cmMode = 1'b0;
  logic        satEn = 1'b0;
  logic [35:0] result;
  logic        flagN, flagV, flagC, flagE, flagZ, done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  acc_shift_unit u_acc_shift_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .opClass(opClass),
    .operand(operand), .accIn(accIn), .shAmt(shAmt), .cmMode(cmMode), .satEn(satEn),
    .result(result), .flagN(flagN), .flagV(flagV), .flagC(flagC), .flagE(flagE),
    .flagZ(flagZ), .done(done)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  cls;
    logic [35:0] opnd;
    logic [35:0] accv;
    logic [4:0]  amt;
    logic        cm;
    logic        sa;
    logic [35:0] expRes;
    logic [4:0]  expFlg;   // {N,V,C,E,Z}
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 36'h040000000, 36'h0, 5'd0,  1'b0, 1'b0, 36'h080000000, 5'b00010, 4'd5},  // R5
    '{2'd0, 2'd0, 36'h040000000, 36'h0, 5'd0,  1'b1, 1'b0, 36'h080000000, 5'b11010, 4'd4},  // R4
    '{2'd0, 2'd0, 36'h040000000, 36'h0, 5'd0,  1'b0, 1'b1, 36'h07FFFFFFF, 5'b01010, 4'd6},  // R6
    '{2'd0, 2'd0, 36'h800000000, 36'h0, 5'd0,  1'b0, 1'b0, 36'h000000000, 5'b01101, 4'd3},  // R3
    '{2'd0, 2'd0, 36'h800000000, 36'h0, 5'd0,  1'b1, 1'b0, 36'h000000000, 5'b00001, 4'd12}, // R12
    '{2'd0, 2'd1, 36'h0C0000001, 36'h0, 5'd0,  1'b0, 1'b0, 36'h080000002, 5'b10100, 4'd10}, // R10
    '{2'd0, 2'd2, 36'h000004000, 36'h0, 5'd0,  1'b0, 1'b0, 36'h000008000, 5'b11000, 4'd4},  // R4
    '{2'd0, 2'd2, 36'hFFFFF8000, 36'h0, 5'd0,  1'b0, 1'b0, 36'h000000000, 5'b01101, 4'd2},  // R2
    '{2'd0, 2'd3, 36'hC00000000, 36'h0, 5'd0,  1'b0, 1'b1, 36'hF80000000, 5'b11110, 4'd6},  // R6
    '{2'd1, 2'd0, 36'h0000000FF, 36'h0, 5'd28, 1'b0, 1'b0, 36'hFF0000000, 5'b10000, 4'd7},  // R7
    '{2'd1, 2'd0, 36'h0000000FF, 36'h0, 5'd28, 1'b1, 1'b0, 36'hFF0000000, 5'b00000, 4'd11}, // R11
    '{2'd1, 2'd2, 36'h000000003, 36'h0, 5'd15, 1'b0, 1'b0, 36'h000008000, 5'b10100, 4'd7},  // R7
    '{2'd1, 2'd1, 36'h000000000, 36'h0, 5'd0,  1'b0, 1'b0, 36'h000000000, 5'b00001, 4'd12}, // R12
    '{2'd1, 2'd0, 36'h100000000, 36'h0, 5'd1,  1'b1, 1'b0, 36'h200000000, 5'b00011, 4'd5},  // R5
    '{2'd2, 2'd2, 36'h000008000, 36'h000001000, 5'd4, 1'b0, 1'b0, 36'h000000800, 5'b00100, 4'd8}, // R8
    '{2'd3, 2'd2, 36'h000008000, 36'h000001000, 5'd4, 1'b0, 1'b0, 36'h000001800, 5'b00000, 4'd8}, // R8
    '{2'd2, 2'd0, 36'h07FFFFFFF, 36'h000000001, 5'd0, 1'b0, 1'b1, 36'h07FFFFFFF, 5'b11010, 4'd9}, // R9
    '{2'd2, 2'd0, 36'h07FFFFFFF, 36'h000000001, 5'd0, 1'b0, 1'b0, 36'h080000000, 5'b00010, 4'd9}, // R9
    '{2'd2, 2'd0, 36'h800000000, 36'h800000000, 5'd1, 1'b0, 1'b0, 36'h400000000, 5'b01110, 4'd8}, // R8
    '{2'd2, 2'd0, 36'h800000000, 36'h800000000, 5'd1, 1'b0, 1'b1, 36'hF80000000, 5'b01110, 4'd6}, // R6
    '{2'd2, 2'd0, 36'h000000000, 36'h080000000, 5'd0, 1'b1, 1'b0, 36'h080000000, 5'b10010, 4'd9}, // R9
    '{2'd3, 2'd1, 36'h080000000, 36'hFFFFFFFFF, 5'd31, 1'b0, 1'b0, 36'h000000000, 5'b00101, 4'd8} // R8
  };

  task automatic check(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    opcode  = v.op;
    opClass = v.cls;
    operand = v.opnd;
    accIn   = v.accv;
    shAmt   = v.amt;
    cmMode  = v.cm;
    satEn   = v.sa;
    inValid = 1'b1;
  endtask

  task automatic expect_vec(input vec_t v);
    check(int'(v.req), "result", 64'(result), 64'(v.expRes));
    check(int'(v.req), "flags NVCEZ", 64'({flagN, flagV, flagC, flagE, flagZ}), 64'(v.expFlg));
    check(1, "done", 64'(done), 64'd1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=hung expected=complete");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(1, "reset result", 64'(result), 64'd0);
    check(1, "reset flags", 64'({flagN, flagV, flagC, flagE, flagZ}), 64'd0);
    check(1, "reset done", 64'(done), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      inValid = 1'b0;
      expect_vec(VECS[i]);
      @(negedge clk);
      // R1: single-cycle done
      check(1, "done width", 64'(done), 64'd0);
    end

    // R1: back-to-back strobes both complete, done held across them
    drive(VECS[0]);
    @(negedge clk);
    expect_vec(VECS[0]);
    drive(VECS[8]);
    @(negedge clk);
    expect_vec(VECS[8]);
    // R1: inputs changed without a strobe are ignored
    inValid = 1'b0;
    operand = 36'h123456789;
    opcode  = 2'd1;
    shAmt   = 5'd3;
    @(negedge clk);
    @(negedge clk);
    check(1, "idle result hold", 64'(result), 64'(VECS[8].expRes));
    check(1, "idle flags hold", 64'({flagN, flagV, flagC, flagE, flagZ}), 64'(VECS[8].expFlg));
    check(1, "idle done", 64'(done), 64'd0);

    // R1: reset clears outputs again
    rstN = 1'b0;
    @(negedge clk);
    check(1, "re-reset result", 64'(result), 64'd0);
    check(1, "re-reset flags", 64'({flagN, flagV, flagC, flagE, flagZ}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    summary();
  end
endmodule